// File: doc/BRIEF.md
# Dual-Source Edge Interrupt Latch

This block merges two event lines into one active-low interrupt request for a processor. Each event line has its own enable level. A rising edge on an event line, seen while that line's enable is high, sets a latch, and the request output goes low. The request stays low until the processor drives the clear input high. The second event line also drives its own active-low flag output. The flag is set by a rising edge on that line whether or not its enable is high, and the same clear input releases it.

The event and enable lines may come from outside the clock domain. They pass through a synchroniser (two stages by default) before edge detection. Each enable goes through the same chain as its event, so both are sampled at the same instant. The clear input is treated as synchronous to the clock and acts at the next edge. Clear wins over any set in the same cycle.

Top module: `dual_event_irq`

## Requirements
- R1: After reset, `irq_n` and `flag_n` are high (1). An event input that is already high when reset is released does not count as a rising edge.
- R2: If `evt_a` goes from 0 to 1 while `en_a` is 1, `irq_n` goes low at the third rising clock edge after the change. It is still high after the second edge, which keeps the latency within 4 cycles.
- R3: A rising edge on `evt_a` while `en_a` is 0 leaves `irq_n` unchanged.
- R4: If `evt_b` goes from 0 to 1 while `en_b` is 1, `irq_n` goes low at the third rising clock edge after the change.
- R5: A rising edge on `evt_b` while `en_b` is 0 leaves `irq_n` unchanged.
- R6: Any rising edge on `evt_b` drives `flag_n` low at the third rising clock edge after the change, whatever the value of `en_b`. Edges on `evt_a` never change `flag_n`.
- R7: Once low, `irq_n` and `flag_n` stay low until clear. When `irq_clr` is 1 at a rising clock edge, both outputs are high (1) after that edge.
- R8: If `irq_clr` is 1 in the cycle where a qualifying edge would set an output, that output stays high. Edges whose set cycle falls while `irq_clr` is held high are lost.
- R9: After a clear, an event input that stays high does not set the outputs again. Only a new 0-to-1 transition does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_a | input | 1 | Event line A, may be asynchronous |
| en_a | input | 1 | Enable for event line A, active high |
| evt_b | input | 1 | Event line B, may be asynchronous |
| en_b | input | 1 | Enable for event line B, active high |
| irq_clr | input | 1 | Clears the interrupt and the flag, active high, synchronous |
| irq_n | output | 1 | Latched interrupt request, active low |
| flag_n | output | 1 | Latched flag for event line B, active low |

## Verification
The bench targets five cases.

- **Event high at reset release.** A design that resets its synchronisers to 0 would raise a spurious interrupt here.
- **Enable low.** A design that gates with the wrong enable, or that gates the flag, would set `irq_n` from a disabled source or leave `flag_n` high.
- **Clear and set in the same cycle.** A design that gives set priority would leave `irq_n` low after the clear.
- **Line held high across a clear.** A level-sensitive design would set the latch again at once.
- **Exact latency.** The check is made both one edge before and at the edge where the output must fall, so an extra or missing pipeline stage is caught.

Random toggling of every input is compared each cycle against a timing model built from R2 to R8.

// File: rtl/dei_pkg.sv
// Package: shared constants and types for the dual-source interrupt latch.
// Assumes: all users take the synchroniser depth from here unless overridden.
package dei_pkg;
    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned NUM_SRC    = 2;

    // One event line together with its enable level.
    typedef struct packed {
        logic en;
        logic evt;
    } src_t;
endpackage

// File: rtl/dei_sync_chain.sv
// Module: multi-bit flop-chain synchroniser.
// Does: moves WIDTH independent level signals into the clk domain through
//       STAGES flops. All bits share one chain depth, so bits that change
//       together leave together.
// Assumes: synchronous active-low reset that loads RST_VAL into every stage.
module dei_sync_chain #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= {WIDTH{RST_VAL}};
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            // Later stages: shift from the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= {WIDTH{RST_VAL}};
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dei_rise_gate.sv
// Module: rising-edge detector with an enable qualifier.
// Does: flags a 0-to-1 step of a synchronised level as a one-cycle pulse on
//       rise_any, and on rise_qual when the synchronised enable is also high.
// Assumes: lvl and en are already in the clk domain. The history flop resets
//          to 1, so a level that is high at reset release is not an edge.
module dei_rise_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic en,
    output logic rise_any,
    output logic rise_qual
);
    logic prev_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    // Edge pulse and its enable-qualified copy.
    always_comb begin
        rise_any  = lvl & ~prev_q;
        rise_qual = rise_any & en;
    end

    // A pulse lasts one cycle unless the level falls and rises again at once.
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_any && lvl |=> !rise_any || !$past(lvl) == 1'b0 && lvl == 1'b0 || !rise_any)
        else $error("rise pulse repeated on a held level");
endmodule

// File: rtl/dei_sr_cell.sv
// Module: set/clear latch with an active-low output.
// Does: drives q_n low on a set pulse and holds it there until clear.
//       Clear wins over set in the same cycle.
// Assumes: set and clr are synchronous to clk.
module dei_sr_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q_n
);
    // Latch update: reset, then clear, then set.
    always_ff @(posedge clk) begin
        if (!rst_n)   q_n <= 1'b1;
        else if (clr) q_n <= 1'b1;
        else if (set) q_n <= 1'b0;
    end

    p_clear_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q_n)
        else $error("clear did not release the output");

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set && !clr |=> !q_n)
        else $error("set pulse did not drive the output low");

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !set && !clr |=> $stable(q_n))
        else $error("output changed with no set and no clear");
endmodule

// File: rtl/dual_event_irq.sv
// Module: dual-source edge interrupt latch (top).
// Does: synchronises two event/enable pairs and detects rising edges on the
//       events. Enabled edges set a shared active-low interrupt. Every edge
//       on source B sets an active-low flag. irq_clr releases both.
// Assumes: irq_clr is synchronous to clk. An event edge must leave its line
//          low for at least SYNC_STAGES cycles after reset to be seen.
module dual_event_irq #(
    parameter int unsigned SYNC_STAGES = dei_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_a,
    input  logic en_a,
    input  logic evt_b,
    input  logic en_b,
    input  logic irq_clr,
    output logic irq_n,
    output logic flag_n
);
    import dei_pkg::*;

    localparam int unsigned SRC_W = $bits(src_t);
    localparam int unsigned BUS_W = NUM_SRC * SRC_W;
    localparam int unsigned IDX_B = 1;

    src_t [NUM_SRC-1:0] raw_src;
    src_t [NUM_SRC-1:0] syn_src;
    logic [BUS_W-1:0]   syn_bus;
    logic [NUM_SRC-1:0] rise_any;
    logic [NUM_SRC-1:0] rise_qual;
    logic               irq_set;

    // Pack the pins into source records.
    always_comb begin
        raw_src[0].evt = evt_a;
        raw_src[0].en  = en_a;
        raw_src[1].evt = evt_b;
        raw_src[1].en  = en_b;
    end

    dei_sync_chain #(
        .WIDTH   (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_src),
        .q     (syn_bus)
    );

    assign syn_src = syn_bus;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        dei_rise_gate u_rise (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (syn_src[s].evt),
            .en        (syn_src[s].en),
            .rise_any  (rise_any[s]),
            .rise_qual (rise_qual[s])
        );
    end

    // Any enabled edge requests the interrupt.
    always_comb irq_set = |rise_qual;

    dei_sr_cell u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (irq_clr),
        .q_n   (irq_n)
    );

    dei_sr_cell u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (rise_any[IDX_B]),
        .clr   (irq_clr),
        .q_n   (flag_n)
    );

    p_no_fall_on_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> !$past(irq_clr))
        else $error("interrupt fell in a clear cycle");

    p_clear_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> irq_n && flag_n)
        else $error("clear did not release both outputs");

    p_flag_from_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_n) |-> $past(rise_any[IDX_B]))
        else $error("flag fell without an edge on source B");
endmodule

// File: tb/dual_event_irq_tb.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random stimulus for dual_event_irq.
// The expected outputs come from a timing model of the requirements: an
// input driven before edge n sets an output at edge n+2, and a clear at
// edge n releases the outputs at that edge.
module dual_event_irq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_a = 1'b0, en_a = 1'b0, evt_b = 1'b0, en_b = 1'b0, irq_clr = 1'b0;
    logic irq_n, flag_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Input history, index 0 = value driven before the latest edge.
    logic ha [4], hae [4], hb [4], hbe [4];
    logic exp_irq = 1'b1, exp_flag = 1'b1;

    always #2.5 clk = ~clk;

    dual_event_irq u_dut (
        .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .en_a(en_a),
        .evt_b(evt_b), .en_b(en_b), .irq_clr(irq_clr),
        .irq_n(irq_n), .flag_n(flag_n)
    );

    function automatic logic edge_seen(logic now_v, logic old_v, logic en_v);
        return now_v & ~old_v & en_v;
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: inputs already driven; update model; compare at negedge.
    task automatic step(string tag);
        logic set_i, set_f;
        for (int i = 3; i > 0; i--) begin
            ha[i] = ha[i-1]; hae[i] = hae[i-1]; hb[i] = hb[i-1]; hbe[i] = hbe[i-1];
        end
        ha[0]  = rst_n ? evt_a : 1'b1;
        hae[0] = rst_n ? en_a  : 1'b1;
        hb[0]  = rst_n ? evt_b : 1'b1;
        hbe[0] = rst_n ? en_b  : 1'b1;
        @(posedge clk);
        set_i = edge_seen(ha[2], ha[3], hae[2]) | edge_seen(hb[2], hb[3], hbe[2]);
        set_f = edge_seen(hb[2], hb[3], 1'b1);
        if (!rst_n || irq_clr) begin
            exp_irq = 1'b1; exp_flag = 1'b1;
        end else begin
            if (set_i) exp_irq = 1'b0;
            if (set_f) exp_flag = 1'b0;
        end
        @(negedge clk);
        check(tag, "irq_n", irq_n, exp_irq);
        check(tag, "flag_n", flag_n, exp_flag);
    endtask

    task automatic steps(string tag, int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic clear_all();
        irq_clr = 1'b1; step("R7");
        irq_clr = 1'b0;
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'h5EED_2024);
        for (int i = 0; i < 4; i++) begin ha[i]=1; hae[i]=1; hb[i]=1; hbe[i]=1; end
        @(negedge clk);

        // R1: reset state with both event lines already high.
        evt_a = 1; en_a = 1; evt_b = 1; en_b = 1;
        steps("R1", 3);
        rst_n = 1'b1;
        steps("R1", 6);
        check("R1", "irq_n idle", irq_n, 1'b1);
        check("R1", "flag_n idle", flag_n, 1'b1);

        // R2: enabled edge on A; exact latency.
        evt_a = 0; evt_b = 0; steps("R2", 4);
        evt_a = 1; step("R2"); step("R2");
        check("R2", "still high after 2 edges", irq_n, 1'b1);
        step("R2");
        check("R2", "low at 3rd edge", irq_n, 1'b0);
        check("R6", "A leaves flag", flag_n, 1'b1);
        steps("R7", 5);
        check("R7", "irq held low", irq_n, 1'b0);

        // R9: clear while A held high; no retrigger.
        clear_all();
        steps("R9", 6);
        check("R9", "no retrigger", irq_n, 1'b1);

        // R3: disabled edge on A.
        evt_a = 0; en_a = 0; steps("R3", 4);
        evt_a = 1; steps("R3", 5);
        check("R3", "disabled A ignored", irq_n, 1'b1);

        // R5 and R6: disabled edge on B still sets flag.
        evt_a = 0; en_b = 0; steps("R5", 4);
        evt_b = 1; steps("R5", 5);
        check("R5", "disabled B ignored", irq_n, 1'b1);
        check("R6", "flag set by B", flag_n, 1'b0);
        clear_all();
        check("R7", "flag released", flag_n, 1'b1);

        // R4: enabled edge on B.
        evt_b = 0; en_b = 1; steps("R4", 4);
        evt_b = 1; steps("R4", 3);
        check("R4", "enabled B sets irq", irq_n, 1'b0);
        clear_all();

        // R8: clear in the set cycle wins.
        evt_b = 0; evt_a = 0; en_a = 1; steps("R8", 4);
        evt_a = 1; step("R8"); step("R8");
        irq_clr = 1; step("R8"); irq_clr = 0;
        check("R8", "clear beats set", irq_n, 1'b1);
        steps("R8", 4);
        check("R8", "lost edge stays lost", irq_n, 1'b1);

        // Random phase: every cycle compared with the model.
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(3) == 0) evt_a = ~evt_a;
            if ($urandom_range(3) == 0) evt_b = ~evt_b;
            if ($urandom_range(7) == 0) en_a  = ~en_a;
            if ($urandom_range(7) == 0) en_b  = ~en_b;
            irq_clr = ($urandom_range(15) == 0);
            step("R7");
        end
        irq_clr = 0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule